// File: doc/BRIEF.md
# Multiple register transfer sequencer

This block carries out a load-multiple or store-multiple operation between an internal bank of sixteen 32-bit registers and a single-beat memory port. Indices 0 to 7 are data registers D0 to D7, and indices 8 to 15 are address registers A0 to A7. A start pulse supplies three things: the operation word, a 16-bit register selection mask and an effective address that has already been computed. The block then performs one memory access for each selected register, in the order that the addressing mode requires. Each access moves either a 16-bit word or a 32-bit long, and the block steps the address between accesses.

The order of the scan depends on the mode. A store in predecrement mode walks the registers from A7 down to D0 and lowers the address. Every other case walks upward and raises the address. In the two self-modifying modes, predecrement and postincrement, the block places the final address into the base address register. Every other mode leaves that register alone. A test port preloads registers, and a second test port reads them back.

Top module: `mreg_xfer_seq`

## Requirements
- R1: After reset, busy, done and mem_valid are all 0.
- R2: Bit 10 of `instr` selects the direction. When it is 1, memory is read into registers (mem_write=0). When it is 0, registers are written to memory (mem_write=1).
- R3: Bit 6 of `instr` selects the size. When it is 1, each access is a 32-bit long (mem_long=1) and the address step is 4. When it is 0, each access is a 16-bit word (mem_long=0) and the address step is 2. The first access uses `base_addr`.
- R4: Outside predecrement stores, the mask is scanned from bit 0 upward. Mask bit i selects register i, and the address rises by the step between accesses. A mask bit that is clear produces no memory access.
- R5: A store whose mode field (`instr[5:3]`) is 3'b100 scans the mask from bit 0 upward, but mask bit k selects register 15-k. The address falls by the step between accesses and does not change after the last one. At the end, A[`instr[2:0]`] (register 8+n) holds the address of the last access.
- R6: When the mode field is 3'b011, the address also rises by one step after the last access. That final address is then written to A[`instr[2:0]`], and this write takes precedence over any value loaded into that register.
- R7: In every other mode, including mode 3'b100 with a load, no register is modified except those the mask loads.
- R8: A word load writes the sign extension of `mem_rdata[15:0]` to the register. A long load writes `mem_rdata`.
- R9: A word store drives the low 16 bits of the register on `mem_wdata[15:0]`, with zeros in the upper half. A long store drives the whole register.
- R10: With a zero mask there is no memory access, and done is high in the second cycle after the start cycle.
- R11: While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_wdata hold. One access completes in each cycle in which both are high.
- R12: done is high for exactly one cycle, in the second cycle after the last completed access. At that point busy is 0 and every register result can be read on `dbg_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| instr | input | 16 | Operation word: direction bit 10, size bit 6, mode 5:3, base register 2:0 |
| mask | input | 16 | Register selection mask |
| base_addr | input | 32 | Precomputed first address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | 1 = 32-bit, 0 = 16-bit access |
| mem_addr | output | 32 | Byte address (big-endian memory) |
| mem_wdata | output | 32 | Write data, word data in bits 15:0 |
| mem_rdata | input | 32 | Read data, word data in bits 15:0 |
| pl_we | input | 1 | Test preload write enable (ignored while busy) |
| pl_idx | input | 4 | Test preload register index |
| pl_data | input | 32 | Test preload value |
| dbg_idx | input | 4 | Test read register index |
| dbg_data | output | 32 | Test read value (combinational) |

## Verification
The bench predicts, at the moment each operation starts, the exact list of memory accesses and the final register file. It compares every completed access against the head of that list in the same cycle as the handshake. While a request is stalled, it checks that the request is unchanged on the next cycle. done is expected exactly two cycles after the last handshake, or two cycles after the start cycle when the mask is zero, and the bench flags done in any other cycle. The register file is read back through the test port only after done, when nothing can still change it.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam int DIR_BIT  = 10;
  localparam int SIZE_BIT = 6;
  localparam int MODE_LO  = 3;
  localparam logic [2:0] MODE_PREDEC  = 3'b100;
  localparam logic [2:0] MODE_POSTINC = 3'b011;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_st_t;
endpackage

// File: rtl/mrx_pick.sv
module mrx_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mrx_regbank.sv
module mrx_regbank #(
  parameter int N = 16,
  parameter int W = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [W-1:0]  rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic en;
    assign en = we && (widx == IW'(g));
    always_ff @(posedge clk) begin
      if (en) regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[ridx_a];
  assign rdata_b = regs[ridx_b];
endmodule

// File: rtl/mreg_xfer_seq.sv
module mreg_xfer_seq #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int AW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [15:0]             instr,
  input  logic [NREG-1:0]         mask,
  input  logic [AW-1:0]           base_addr,
  output logic                    busy,
  output logic                    done,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_write,
  output logic                    mem_long,
  output logic [AW-1:0]           mem_addr,
  output logic [XLEN-1:0]         mem_wdata,
  input  logic [XLEN-1:0]         mem_rdata,
  input  logic                    pl_we,
  input  logic [$clog2(NREG)-1:0] pl_idx,
  input  logic [XLEN-1:0]         pl_data,
  input  logic [$clog2(NREG)-1:0] dbg_idx,
  output logic [XLEN-1:0]         dbg_data
);
  import mrx_pkg::*;

  localparam int IW   = $clog2(NREG);
  localparam int HALF = XLEN / 2;
  localparam int ABASE = NREG / 2;

  seq_st_t        state_q, state_d;
  logic [NREG-1:0] pend_q, pend_d, pend_clr;
  logic [AW-1:0]  addr_q, addr_d, step;
  logic           dir_q, long_q, rev_q, post_q, wb_q, done_q, done_d;
  logic [2:0]     rn_q;
  logic           found, xfer, more, accept;
  logic [IW-1:0]  bit_idx, reg_idx, wb_idx;
  logic [2:0]     mode_in;
  logic           rev_in, post_in;
  logic           wr_en;
  logic [IW-1:0]  wr_idx;
  logic [XLEN-1:0] wr_dat, rd_a, ld_val;

  mrx_pick #(.N(NREG)) u_pick (
    .vec(pend_q), .found(found), .idx(bit_idx)
  );

  mrx_regbank #(.N(NREG), .W(XLEN)) u_bank (
    .clk(clk), .we(wr_en), .widx(wr_idx), .wdata(wr_dat),
    .ridx_a(reg_idx), .rdata_a(rd_a), .ridx_b(dbg_idx), .rdata_b(dbg_data)
  );

  // decode of the incoming operation word
  assign mode_in = instr[MODE_LO +: 3];
  assign rev_in  = !instr[DIR_BIT] && (mode_in == MODE_PREDEC);
  assign post_in = !rev_in && (mode_in == MODE_POSTINC);
  assign accept  = (state_q == ST_IDLE) && start;

  // reverse scan: mask bit k names register NREG-1-k
  assign reg_idx  = rev_q ? IW'(NREG - 1) - bit_idx : bit_idx;
  assign wb_idx   = IW'(ABASE) + IW'(rn_q);
  assign pend_clr = pend_q & ~(NREG'(1) << bit_idx);
  assign more     = |pend_clr;
  assign step     = long_q ? AW'(4) : AW'(2);

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign mem_valid = (state_q == ST_RUN) && found;
  assign mem_write = !dir_q;
  assign mem_long  = long_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = long_q ? rd_a : {{HALF{1'b0}}, rd_a[HALF-1:0]};
  assign xfer      = mem_valid && mem_ready;
  assign ld_val    = long_q ? mem_rdata
                            : {{HALF{mem_rdata[HALF-1]}}, mem_rdata[HALF-1:0]};

  // next state
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    if (accept) begin
      state_d = ST_RUN;
      pend_d  = mask;
      addr_d  = base_addr;
    end else if (state_q == ST_RUN) begin
      if (!found) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end else if (xfer) begin
        pend_d = pend_clr;
        if (more)        addr_d = rev_q ? addr_q - step : addr_q + step;
        else if (post_q) addr_d = addr_q + step;
      end
    end
  end

  // register bank write port: sequencer first, preload only when idle
  always_comb begin
    wr_en  = 1'b0;
    wr_idx = pl_idx;
    wr_dat = pl_data;
    if (state_q == ST_RUN) begin
      if (xfer && dir_q) begin
        wr_en  = 1'b1;
        wr_idx = reg_idx;
        wr_dat = ld_val;
      end else if (!found && wb_q) begin
        wr_en  = 1'b1;
        wr_idx = wb_idx;
        wr_dat = XLEN'(addr_q);
      end
    end else if (pl_we) begin
      wr_en = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      long_q <= 1'b0;
      rev_q  <= 1'b0;
      post_q <= 1'b0;
      wb_q   <= 1'b0;
      rn_q   <= '0;
    end else if (accept) begin
      dir_q  <= instr[DIR_BIT];
      long_q <= instr[SIZE_BIT];
      rev_q  <= rev_in;
      post_q <= post_in;
      wb_q   <= rev_in || post_in;
      rn_q   <= instr[2:0];
    end
  end

  // checks
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && more |=> mem_valid && (mem_addr == ($past(rev_q) ? $past(mem_addr) - $past(step)
                                                             : $past(mem_addr) + $past(step))));

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_valid);
endmodule

// File: tb/mreg_xfer_seq_tb.sv
module mreg_xfer_seq_tb;
  logic        clk, rst_n, start;
  logic [15:0] instr, mask;
  logic [31:0] base_addr;
  logic        busy, done, mem_valid, mem_ready, mem_write, mem_long;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        pl_we;
  logic [3:0]  pl_idx, dbg_idx;
  logic [31:0] pl_data, dbg_data;

  mreg_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .mask(mask),
    .base_addr(base_addr), .busy(busy), .done(done), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_long(mem_long),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pl_we(pl_we), .pl_idx(pl_idx), .pl_data(pl_data),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  logic [31:0] exp_regs [16];
  logic [31:0] q_addr[$], q_wdata[$];
  bit          q_wr[$], q_long[$];
  bit          active = 0, op_done = 0, stall_prev = 0, cur_word = 0;
  int          since = 0;
  logic [31:0] stall_addr, stall_wdata;
  logic [7:0]  lfsr = 8'h5B;
  string       ord_tag = "R4";

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0] + 16'h8001};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory responder and cycle-by-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = lfsr[0] | lfsr[2];
    mem_rdata = memf(mem_addr);
    if (active) begin
      if (stall_prev) begin
        chk(mem_valid && mem_addr == stall_addr && mem_wdata == stall_wdata,
            "R11", "stalled request held", mem_addr, stall_addr);
      end
      stall_prev = mem_valid && !mem_ready;
      stall_addr = mem_addr;
      stall_wdata = mem_wdata;
      if (start && !busy) begin
        since = 0;
      end else if (mem_valid && mem_ready) begin
        since = 0;
        if (q_addr.size() == 0) begin
          chk(0, "R10", "access beyond selected mask", mem_addr, 32'h0);
        end else begin
          chk(mem_addr == q_addr[0], ord_tag, "access address", mem_addr, q_addr[0]);
          chk(mem_write == q_wr[0], "R2", "direction", {31'h0, mem_write}, {31'h0, q_wr[0]});
          chk(mem_long == q_long[0], "R3", "size", {31'h0, mem_long}, {31'h0, q_long[0]});
          if (q_wr[0])
            chk(mem_wdata == q_wdata[0], cur_word ? "R9" : "R2", "write data", mem_wdata, q_wdata[0]);
          void'(q_addr.pop_front()); void'(q_wdata.pop_front());
          void'(q_wr.pop_front());   void'(q_long.pop_front());
        end
      end else begin
        since++;
        if (q_addr.size() == 0 && since == 2) begin
          chk(done && !busy, "R12", "done two cycles after last access", {31'h0, done}, 32'h1);
          active = 0;
          op_done = 1;
        end else if (done) begin
          chk(0, "R12", "early done", 32'h1, 32'h0);
        end
      end
    end
  end

  task automatic run_op(input bit ld, input bit lng, input logic [2:0] mode,
                        input logic [2:0] rn, input logic [15:0] m, input logic [31:0] base);
    bit rev;
    logic [31:0] a, st, d;
    int reg_i, left;
    rev = !ld && (mode == 3'b100);
    st = lng ? 32'd4 : 32'd2;
    a = base;
    left = $countones(m);
    cur_word = !lng;
    ord_tag = rev ? "R5" : "R4";
    for (int j = 0; j < 16; j++) begin
      if (m[j]) begin
        reg_i = rev ? 15 - j : j;
        q_addr.push_back(a); q_wr.push_back(!ld); q_long.push_back(lng);
        d = lng ? exp_regs[reg_i] : {16'h0, exp_regs[reg_i][15:0]};
        q_wdata.push_back(d);
        if (ld) begin
          d = memf(a);
          exp_regs[reg_i] = lng ? d : {{16{d[15]}}, d[15:0]};
        end
        left--;
        if (left > 0) a = rev ? a - st : a + st;
        else if (mode == 3'b011) a = a + st;
      end
    end
    if (rev || mode == 3'b011) exp_regs[8 + rn] = a;
    @(posedge clk); #1;
    instr = 16'h4880 | (16'(ld) << 10) | (16'(lng) << 6) | (16'(mode) << 3) | 16'(rn);
    mask = m; base_addr = base; start = 1; active = 1;
    @(posedge clk); #1;
    start = 0;
    wait (op_done);
    op_done = 0;
    chk(q_addr.size() == 0, ord_tag, "all accesses made", q_addr.size(), 32'h0);
    for (int i = 0; i < 16; i++) begin
      dbg_idx = 4'(i); #1;
      chk(dbg_data == exp_regs[i],
          (i >= 8 && 3'(i - 8) == rn) ? (rev ? "R5" : (mode == 3'b011 ? "R6" : "R7"))
                                      : (ld && !lng ? "R8" : "R7"),
          $sformatf("register %0d", i), dbg_data, exp_regs[i]);
    end
  endtask

  initial begin
    rst_n = 0; start = 0; instr = 0; mask = 0; base_addr = 0;
    pl_we = 0; pl_idx = 0; pl_data = 0; dbg_idx = 0;
    mem_ready = 0; mem_rdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    chk(!busy && !done && !mem_valid, "R1", "reset outputs", {29'h0, busy, done, mem_valid}, 32'h0);
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1;
      pl_we = 1; pl_idx = 4'(i);
      pl_data = 32'hC0DE_8000 ^ (32'(i) * 32'h0101_1357);
      exp_regs[i] = pl_data;
    end
    @(posedge clk); #1 pl_we = 0;

    run_op(0, 1, 3'b101, 3'd1, 16'h8301, 32'h0000_4000); // R4 long store, no writeback (R7)
    run_op(1, 1, 3'b011, 3'd2, 16'h0C12, 32'h0000_2000); // R6 long load postinc into base
    run_op(0, 0, 3'b100, 3'd7, 16'h0181, 32'h0000_0100); // R5 word store predec
    run_op(1, 0, 3'b111, 3'd0, 16'h0F0F, 32'h0000_7FFA); // R8 word load sign extension
    run_op(0, 0, 3'b000, 3'd3, 16'h0000, 32'h0000_1234); // R10 zero mask, no writeback
    run_op(1, 1, 3'b011, 3'd3, 16'h0000, 32'h0000_5678); // R10 zero mask with postinc base
    run_op(0, 0, 3'b011, 3'd4, 16'h00F0, 32'h0000_3000); // R9 word store postinc
    run_op(1, 1, 3'b100, 3'd5, 16'h0006, 32'h0000_6000); // R7 predec mode load scans forward
    run_op(0, 1, 3'b100, 3'd6, 16'hFFFF, 32'h0000_9000); // R5 full mask reverse long store

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule